// File: doc/BRIEF.md
# Self-Rate-Learning Manchester Receiver

This block takes a single Manchester-coded line and recovers its data bits without knowing the bit rate in advance. It runs from a system clock that oversamples the line. The line passes through a synchroniser, and each transition is timestamped with a saturating counter. The receiver watches the spacing between transitions. It declares lock only when a short spacing is followed by one roughly twice as long. That pattern can only come from a change of bit value, so the short spacing is the half-bit period.

Once locked, every mid-bit transition starts a blanking window of 1.5 half-bit periods. Any transition inside the window is a boundary transition and is skipped. The first transition after the window is the next mid-bit transition, and its direction gives the bit. The receiver falls back to acquisition when the line goes quiet for longer than three half-bit periods. It also falls back when a transition arrives far too early to be legal. One build therefore serves rates that differ by ten times or more. The only limit is the lower bound on samples per half bit.

Top module: `mdec_adaptive`

## Requirements
- R1: While reset is held and on the cycle it is released, `bit_vld` and `locked` are 0 and `half_per` is 0.
- R2: A decoded bit appears on `bit_vld` as a single-cycle pulse, exactly 3 clock cycles after the line transition at the middle of that bit.
- R3: A rising mid-bit transition (low then high) decodes as 1, and a falling one decodes as 0.
- R4: In acquisition, lock is declared at a transition whose interval L follows an interval S with 2L >= 3S, 2L <= 5S, S >= MIN_HALF, and neither interval saturated. `half_per` then becomes S, and that transition is decoded as a bit.
- R5: A line whose transitions are all equally spaced (alternating data at one rate) never raises `locked` and produces no `bit_vld`.
- R6: While locked, a transition fewer than 1.5 x `half_per` cycles after the last mid-bit transition is not decoded. Constant data (all ones, all zeros) therefore decodes correctly despite its boundary transitions.
- R7: While locked, if no mid-bit transition arrives within 3 x `half_per` cycles, `locked` falls and `half_per` returns to 0.
- R8: While locked, a transition that follows the previous transition by fewer than `half_per`/2 cycles drops lock, and no bit is decoded for it.
- R9: Without reconfiguration, the same instance decodes streams with 4, 16 and 40 clock cycles per half bit.
- R10: `half_per` holds one value for the whole time `locked` stays high, and `bit_vld` is never high while `locked` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | 1 | Asynchronous Manchester-coded line |
| bit_out | output | 1 | Most recently decoded bit |
| bit_vld | output | 1 | One-cycle strobe marking a new `bit_out` |
| locked | output | 1 | High while the bit period is learned and tracked |
| half_per | output | CNT_W | Learned half-bit period in clock cycles, 0 when unlocked |

## Verification
Each decoded bit is due exactly 3 cycles after the mid-bit line change that carries it: two synchroniser stages plus the registered output. The driver stamps every expected bit with that due cycle when it drives the transition. The monitor then compares the bit value, the learned half period and the cycle of arrival against the stamp. Any strobe with no pending item counts as a failure, and so does a stamp left unserved. Loss of lock is slower and depends on the rate. It is therefore sampled at a fixed point, after an idle stretch longer than the three-half-period timeout plus the pipeline delay, or several cycles after an injected glitch.

// File: rtl/mdec_pkg.sv
package mdec_pkg;
  typedef enum logic {
    ST_ACQ   = 1'b0,
    ST_TRACK = 1'b1
  } trk_state_e;
endpackage

// File: rtl/mdec_line_sync.sv
// Brings the asynchronous line into the clock domain and flags transitions.
module mdec_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_in,
  output logic edge_o,
  output logic rise_o
);
  localparam int SH_W = SYNC_STAGES + 1;

  logic [SH_W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[SH_W-2:0], line_in};
  end

  // sh_q[SYNC_STAGES-1] is the settled sample, sh_q[SYNC_STAGES] the one before
  assign edge_o = sh_q[SYNC_STAGES-1] ^ sh_q[SYNC_STAGES];
  assign rise_o = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
endmodule

// File: rtl/mdec_gap_count.sv
// Counts clocks since the previous transition; sticks at all-ones.
module mdec_gap_count #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             edge_i,
  output logic [CNT_W-1:0] gap_o,
  output logic             gap_sat_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                 cnt_q <= CNT_MAX;  // unknown age counts as saturated
    else if (edge_i)         cnt_q <= CNT_ONE;
    else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_ONE;
  end

  assign gap_o     = cnt_q;
  assign gap_sat_o = (cnt_q == CNT_MAX);
endmodule

// File: rtl/mdec_ratio_chk.sv
// Decides whether (prev, cur) is a short/long pair with long about twice short.
module mdec_ratio_chk #(
  parameter int CNT_W    = 12,
  parameter int MIN_HALF = 2
) (
  input  logic [CNT_W-1:0] short_i,
  input  logic             short_ok_i,
  input  logic [CNT_W-1:0] long_i,
  input  logic             long_ok_i,
  output logic             pair_ok_o
);
  localparam int EW = CNT_W + 3;

  logic [EW-1:0] long_x2, short_x3, short_x5;

  always_comb begin
    long_x2   = EW'(long_i) << 1;
    short_x3  = EW'(short_i) * EW'(3);
    short_x5  = EW'(short_i) * EW'(5);
    pair_ok_o = short_ok_i && long_ok_i &&
                (short_i >= CNT_W'(MIN_HALF)) &&
                (long_x2 >= short_x3) && (long_x2 <= short_x5);
  end
endmodule

// File: rtl/mdec_tracker.sv
// Acquisition and tracking state machine with blanking and bit decision.
module mdec_tracker
  import mdec_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             edge_i,
  input  logic             rise_i,
  input  logic [CNT_W-1:0] gap_i,
  input  logic             gap_sat_i,
  input  logic             pair_ok_i,
  output logic [CNT_W-1:0] prev_o,
  output logic             prev_ok_o,
  output logic             bit_o,
  output logic             vld_o,
  output logic             lock_o,
  output logic [CNT_W-1:0] half_o
);
  localparam int MW = CNT_W + 2;
  localparam logic [MW-1:0] MID_MAX = '1;
  localparam logic [MW-1:0] MID_ONE = MW'(1);

  trk_state_e       st_q;
  logic [CNT_W-1:0] prev_q, half_q;
  logic             prev_ok_q, bit_q, vld_q, lock_q;
  logic [MW-1:0]    mid_cnt_q;
  logic [MW-1:0]    blank_w, limit_w;
  logic             too_short;

  always_comb begin
    blank_w   = MW'(half_q) + MW'(half_q >> 1);     // 1.5 half periods
    limit_w   = MW'(half_q) * MW'(3);               // 3 half periods
    too_short = gap_i < (half_q >> 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_ACQ;
      prev_q    <= '0;
      prev_ok_q <= 1'b0;
      half_q    <= '0;
      mid_cnt_q <= '0;
      bit_q     <= 1'b0;
      vld_q     <= 1'b0;
      lock_q    <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      case (st_q)
        ST_ACQ: begin
          if (edge_i) begin
            if (pair_ok_i) begin
              st_q      <= ST_TRACK;
              half_q    <= prev_q;
              mid_cnt_q <= MID_ONE;
              bit_q     <= rise_i;
              vld_q     <= 1'b1;
              lock_q    <= 1'b1;
            end else begin
              prev_q    <= gap_i;
              prev_ok_q <= ~gap_sat_i;
            end
          end
        end
        ST_TRACK: begin
          if (mid_cnt_q != MID_MAX) mid_cnt_q <= mid_cnt_q + MID_ONE;
          if (edge_i) begin
            if (too_short) begin
              st_q      <= ST_ACQ;
              lock_q    <= 1'b0;
              half_q    <= '0;
              prev_q    <= '0;
              prev_ok_q <= 1'b0;
            end else if (mid_cnt_q >= blank_w) begin
              bit_q     <= rise_i;
              vld_q     <= 1'b1;
              mid_cnt_q <= MID_ONE;
            end
          end else if (mid_cnt_q > limit_w) begin
            st_q      <= ST_ACQ;
            lock_q    <= 1'b0;
            half_q    <= '0;
            prev_q    <= '0;
            prev_ok_q <= 1'b0;
          end
        end
        default: st_q <= ST_ACQ;
      endcase
    end
  end

  assign prev_o    = prev_q;
  assign prev_ok_o = prev_ok_q;
  assign bit_o     = bit_q;
  assign vld_o     = vld_q;
  assign lock_o    = lock_q;
  assign half_o    = half_q;
endmodule

// File: rtl/mdec_adaptive.sv
module mdec_adaptive #(
  parameter int CNT_W       = 12,
  parameter int MIN_HALF    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_in,
  output logic             bit_out,
  output logic             bit_vld,
  output logic             locked,
  output logic [CNT_W-1:0] half_per
);
  logic             edge_w, rise_w, gap_sat_w, pair_ok_w, prev_ok_w;
  logic [CNT_W-1:0] gap_w, prev_w;

  mdec_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .line_in(line_in),
    .edge_o(edge_w), .rise_o(rise_w)
  );

  mdec_gap_count #(.CNT_W(CNT_W)) u_gap (
    .clk(clk), .rst(rst), .edge_i(edge_w),
    .gap_o(gap_w), .gap_sat_o(gap_sat_w)
  );

  mdec_ratio_chk #(.CNT_W(CNT_W), .MIN_HALF(MIN_HALF)) u_ratio (
    .short_i(prev_w), .short_ok_i(prev_ok_w),
    .long_i(gap_w), .long_ok_i(~gap_sat_w),
    .pair_ok_o(pair_ok_w)
  );

  mdec_tracker #(.CNT_W(CNT_W)) u_trk (
    .clk(clk), .rst(rst), .edge_i(edge_w), .rise_i(rise_w),
    .gap_i(gap_w), .gap_sat_i(gap_sat_w), .pair_ok_i(pair_ok_w),
    .prev_o(prev_w), .prev_ok_o(prev_ok_w),
    .bit_o(bit_out), .vld_o(bit_vld), .lock_o(locked), .half_o(half_per)
  );
endmodule

// File: rtl/mdec_adaptive_chk.sv
module mdec_adaptive_chk #(
  parameter int CNT_W    = 12,
  parameter int MIN_HALF = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             bit_vld,
  input logic             locked,
  input logic [CNT_W-1:0] half_per
);
  AST_VLD_NEEDS_LOCK: assert property (@(posedge clk) disable iff (rst)
    bit_vld |-> locked); // R10

  AST_HALF_HELD: assert property (@(posedge clk) disable iff (rst)
    (locked && $past(locked)) |-> (half_per == $past(half_per))); // R10

  AST_UNLOCK_CLEARS_HALF: assert property (@(posedge clk) disable iff (rst)
    !locked |-> (half_per == '0)); // R7

  AST_LOCK_EMITS_BIT: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> bit_vld); // R4

  AST_HALF_FLOOR: assert property (@(posedge clk) disable iff (rst)
    locked |-> (half_per >= CNT_W'(MIN_HALF))); // R4

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    bit_vld |=> !bit_vld); // R2
endmodule

bind mdec_adaptive mdec_adaptive_chk #(.CNT_W(CNT_W), .MIN_HALF(MIN_HALF)) u_chk (
  .clk(clk), .rst(rst), .bit_vld(bit_vld), .locked(locked), .half_per(half_per)
);

// File: tb/tb_mdec_adaptive.sv
module tb_mdec_adaptive;
  localparam int CNT_W = 12;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             line_in = 1'b0;
  logic             bit_out, bit_vld, locked;
  logic [CNT_W-1:0] half_per;

  int  checks = 0;
  int  fails  = 0;
  int  cyc    = 0;
  bit  done   = 1'b0;
  logic [15:0] lf = 16'hACE1;

  typedef struct packed {
    logic        b;
    logic [15:0] h;
    logic [31:0] due;
  } exp_t;
  exp_t q[$];

  mdec_adaptive #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst(rst), .line_in(line_in),
    .bit_out(bit_out), .bit_vld(bit_vld), .locked(locked), .half_per(half_per)
  );

  always #10 clk = ~clk;  // 50 MHz
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // monitor: scoreboard pop and compare
  always @(negedge clk) begin
    if (!rst && bit_vld) begin
      if (q.size() == 0) begin
        chk(1'b0, "R5/R10 unexpected strobe", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(bit_out == e.b, "R3 bit value", int'(bit_out), int'(e.b));
        chk(half_per == CNT_W'(e.h), "R4/R9 half period", int'(half_per), int'(e.h));
        chk(cyc == int'(e.due), "R2 strobe cycle", cyc, int'(e.due));
      end
    end
  end

  task automatic put_level(input logic lvl, input int n);
    line_in = lvl;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b, input int h, input bit expect_it);
    exp_t e;
    put_level(~b, h);
    if (expect_it) begin
      e.b = b; e.h = 16'(h); e.due = 32'(cyc + 3);
      q.push_back(e);
    end
    put_level(b, h);
  endtask

  task automatic idle_and_check(input int h, input string what);
    put_level(1'b0, 4 * h + 20);
    chk(locked == 1'b0, {"R7 lock dropped after ", what}, int'(locked), 0);
    chk(half_per == '0, {"R7 half cleared after ", what}, int'(half_per), 0);
    chk(q.size() == 0, {"R2 missing strobes after ", what}, q.size(), 0);
  endtask

  task automatic send_stream(input int h, input logic [31:0] pay, input int n, input string what);
    send_bit(1'b0, h, 1'b0);
    send_bit(1'b0, h, 1'b0);
    send_bit(1'b1, h, 1'b1);  // long interval after short: lock point (R4)
    chk(locked == 1'b1, {"R4 locked after preamble ", what}, int'(locked), 1);
    for (int i = 0; i < n; i++) send_bit(pay[i], h, 1'b1);
    idle_and_check(h, what);
  endtask

  function automatic logic [31:0] next_rand();
    logic [31:0] r;
    for (int i = 0; i < 32; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      r[i] = lf[0];
    end
    return r;
  endfunction

  initial begin
    repeat (4) @(negedge clk);
    chk(bit_vld == 1'b0, "R1 reset strobe", int'(bit_vld), 0);
    chk(locked == 1'b0, "R1 reset lock", int'(locked), 0);
    chk(half_per == '0, "R1 reset half", int'(half_per), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(locked == 1'b0 && bit_vld == 1'b0, "R1 after release", int'(locked), 0);

    // R9: three rates spanning ten times, random data
    send_stream(4,  next_rand(), 32, "R9 h4");
    send_stream(16, next_rand(), 32, "R9 h16");
    send_stream(40, next_rand(), 24, "R9 h40");
    // R6: constant data with boundary transitions to blank
    send_stream(16, 32'hFFFF_FFFF, 20, "R6 ones");
    send_stream(8,  32'h0000_0000, 20, "R6 zeros");
    // alternating payload after lock
    send_stream(4,  32'h5555_5555, 24, "R3 alternating");

    // R5: alternating data only, starting with 1 so every spacing is equal
    for (int i = 0; i < 16; i++) send_bit(i[0] ? 1'b0 : 1'b1, 16, 1'b0);
    chk(locked == 1'b0, "R5 no lock on equal spacing", int'(locked), 0);
    idle_and_check(16, "R5 stream");

    // R8: glitch shortly after a mid-bit transition while locked
    send_bit(1'b0, 16, 1'b0);
    send_bit(1'b0, 16, 1'b0);
    begin
      exp_t e;
      put_level(1'b0, 16);
      e.b = 1'b1; e.h = 16'd16; e.due = 32'(cyc + 3);
      q.push_back(e);
      put_level(1'b1, 4);
      put_level(1'b0, 2);
      put_level(1'b1, 10);
    end
    chk(locked == 1'b0, "R8 glitch drops lock", int'(locked), 0);
    chk(half_per == '0, "R8 glitch clears half", int'(half_per), 0);
    idle_and_check(16, "R8 glitch");

    // relock after all of the above
    send_stream(12, next_rand(), 16, "R9 h12 relock");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 200000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule